// File: doc/BRIEF.md
# Three-Phase Charge Transfer Clock Sequencer

This block drives the three gate phases of one charge-coupled register. While no transfer runs it holds the collection pattern: phases one and two are high, and phase three is low and acts as the barrier between neighbouring packets. A start pulse in shift mode runs one transfer. The transfer first gathers every packet under phase one. It then hands each packet forward, first to phase two, then to phase three, and finally back to phase one. At each hand-off the phase ahead rises while the current phase is still high, and the current phase drops only after that. One complete run moves every packet by exactly one pixel. The block then gives a one-cycle done pulse and returns to the collection pattern.

A run has two timing values. The dwell count sets how long each single-phase hold lasts. The overlap count sets how long two neighbouring phases are high together during a hand-off. Both values are captured when a run starts. One instance can drive the row register and a second instance the serial register, each from its own clock. The block has no data stream, so every pin is a plain control or status level. Start is a request with no back-pressure: it is accepted only when the block is idle and in shift mode, and it is dropped in every other case.

Top module: `ccd_phase_seq`

## Requirements
- R1: Out of reset and whenever idle, the outputs are p1=1, p2=1, p3=0, with busy=0 and done=0.
- R2: A start with shift_mode_i=1 while idle makes busy go high at the next edge and holds the pattern p1=1, p2=0, p3=0 for the dwell length.
- R3: After the gather step, the patterns {p1,p2,p3} follow in the order 110, 010, 011, 001, 101, 100. Overlap steps (110, 011, 101) last the overlap length and hold steps (010, 001, 100) last the dwell length.
- R4: A phase rises only while the phase behind it is high: p2 rises with p1 high, p3 rises with p2 high, and p1 rises with p3 high.
- R5: A dwell or overlap count of zero gives a step of one cycle. Any other count N gives N cycles.
- R6: At no cycle are all three phases high, and at no cycle are all three low.
- R7: After the last hold step, done is high for exactly one cycle. In that cycle the outputs show 110 and busy is still high. In the next cycle the block is idle.
- R8: A start that arrives while busy is high is ignored. The run in progress keeps its timing and no second run follows.
- R9: A start with shift_mode_i=0 (integrate) is ignored. The outputs stay 110 and busy stays low.
- R10: dwell_i and ovl_i are sampled at the accepted start. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one single-pixel transfer |
| shift_mode_i | input | 1 | 1 = shift mode, 0 = integrate mode (start ignored) |
| dwell_i | input | DWELL_W | Cycles per single-phase hold step (0 treated as 1) |
| ovl_i | input | OVL_W | Cycles per two-phase overlap step (0 treated as 1) |
| p1_o | output | 1 | Gate phase one drive |
| p2_o | output | 1 | Gate phase two drive |
| p3_o | output | 1 | Gate phase three drive |
| busy_o | output | 1 | A transfer is in progress, up to and including the done cycle |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Some properties are checked by assertions in every cycle:
- the barrier rule, that the phases are never all high and never all low;
- the rise-behind-a-high-phase ordering of every hand-off;
- the single-cycle done pulse and its collection pattern;
- that busy holds until done;
- the idle pattern;
- that a start in integrate mode is refused.

Other behaviour is shown only by the bench scenarios. These cover the exact length of every step, the full order of the patterns, the zero-count rule, and the fact that a stray start or a change of the count inputs during a run leaves the run untouched. The bench checks these by comparing each cycle against a predicted pattern stream.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GATHER,
    ST_OV12,
    ST_HOLD2,
    ST_OV23,
    ST_HOLD3,
    ST_OV31,
    ST_HOLD1,
    ST_DONE
  } seq_state_t;

  // Steps where two neighbouring phases are high together.
  function automatic logic is_overlap(input seq_state_t s);
    return (s == ST_OV12) || (s == ST_OV23) || (s == ST_OV31);
  endfunction
endpackage

// File: rtl/ccd_step_timer.sv
module ccd_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ccd_phase_decode.sv
module ccd_phase_decode
  import ccd_seq_pkg::*;
(
  input  seq_state_t state,
  output logic [2:0] phases,   // {p1,p2,p3}
  output logic       busy,
  output logic       done
);
  always_comb begin
    unique case (state)
      ST_GATHER: phases = 3'b100;
      ST_OV12:   phases = 3'b110;
      ST_HOLD2:  phases = 3'b010;
      ST_OV23:   phases = 3'b011;
      ST_HOLD3:  phases = 3'b001;
      ST_OV31:   phases = 3'b101;
      ST_HOLD1:  phases = 3'b100;
      default:   phases = 3'b110;   // idle and done: collection pattern
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/ccd_phase_seq.sv
module ccd_phase_seq
  import ccd_seq_pkg::*;
#(
  parameter int DWELL_W = 8,
  parameter int OVL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               shift_mode_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic [OVL_W-1:0]   ovl_i,
  output logic               p1_o,
  output logic               p2_o,
  output logic               p3_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int CNT_W = (DWELL_W > OVL_W) ? DWELL_W : OVL_W;

  seq_state_t         state_q, state_d;
  logic [DWELL_W-1:0] dwell_q;
  logic [OVL_W-1:0]   ovl_q;
  logic               tmr_load, tmr_zero;
  logic [CNT_W-1:0]   tmr_val;
  logic [2:0]         phases;

  // Step length minus one; a zero count collapses to a single cycle.
  function automatic logic [CNT_W-1:0] step_reload(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic seq_state_t succ(input seq_state_t s);
    unique case (s)
      ST_GATHER: return ST_OV12;
      ST_OV12:   return ST_HOLD2;
      ST_HOLD2:  return ST_OV23;
      ST_OV23:   return ST_HOLD3;
      ST_HOLD3:  return ST_OV31;
      ST_OV31:   return ST_HOLD1;
      ST_HOLD1:  return ST_DONE;
      default:   return ST_IDLE;
    endcase
  endfunction

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start_i && shift_mode_i) begin
        state_d  = ST_GATHER;
        tmr_load = 1'b1;
        tmr_val  = step_reload(CNT_W'(dwell_i));
      end
      ST_DONE: state_d = ST_IDLE;
      default: if (tmr_zero) begin
        state_d  = succ(state_q);
        tmr_load = 1'b1;
        tmr_val  = is_overlap(succ(state_q)) ? step_reload(CNT_W'(ovl_q))
                                             : step_reload(CNT_W'(dwell_q));
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dwell_q <= '0;
      ovl_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i && shift_mode_i) begin
        dwell_q <= dwell_i;
        ovl_q   <= ovl_i;
      end
    end
  end

  ccd_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ccd_phase_decode u_decode (
    .state  (state_q),
    .phases (phases),
    .busy   (busy_o),
    .done   (done_o)
  );

  assign {p1_o, p2_o, p3_o} = phases;

  // Barrier and hold rules on the driven phases.
  p_no_all_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1_o && p2_o && p3_o));
  p_no_all_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_o || p2_o || p3_o));

  // Each phase rises only while the phase behind it still holds the packet.
  p_rise2_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p2_o) |-> p1_o);
  p_rise3_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p3_o) |-> p2_o);
  p_rise1_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p1_o) |-> p3_o);

  p_idle_pattern_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (p1_o && p2_o && !p3_o && !done_o));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  p_done_pattern_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (p1_o && p2_o && !p3_o && busy_o));
  p_busy_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  p_integrate_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !shift_mode_i) |=> !busy_o);
endmodule

// File: tb/ccd_phase_seq_test.sv
module ccd_phase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b1;
  logic [DW-1:0] dwell = '0;
  logic [OW-1:0] ovl = '0;
  logic p1, p2, p3, busy, done;

  int checks = 0;
  int failures = 0;
  logic  [4:0] exp_q[$];   // {p1,p2,p3,busy,done}
  string tag_q[$];
  string idle_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_phase_seq #(.DWELL_W(DW), .OVL_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .shift_mode_i(mode),
    .dwell_i(dwell), .ovl_i(ovl),
    .p1_o(p1), .p2_o(p2), .p3_o(p3), .busy_o(busy), .done_o(done)
  );

  task automatic push_n(input logic [4:0] v, input int n, input string t);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(t);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // Driver: request one transfer and predict its whole pattern stream.
  task automatic run_shift(input int d, input int o, input string t);
    @(negedge clk);
    start = 1'b1; mode = 1'b1; dwell = DW'(d); ovl = OW'(o);
    push_n(5'b10010, eff(d), t);   // gather, R2
    push_n(5'b11010, eff(o), t);   // overlap 1->2, R4
    push_n(5'b01010, eff(d), t);   // hold 2, R3
    push_n(5'b01110, eff(o), t);
    push_n(5'b00110, eff(d), t);
    push_n(5'b10110, eff(o), t);
    push_n(5'b10010, eff(d), t);
    push_n(5'b11011, 1, t);        // done pulse, R7
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor: compare every cycle after reset, away from the clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        logic [4:0] act, exp;
        string t;
        act = {p1, p2, p3, busy, done};
        if (exp_q.size() != 0) begin
          exp = exp_q.pop_front();
          t = tag_q.pop_front();
        end else begin
          exp = 5'b11000;
          t = idle_tag;
        end
        checks++;
        if (act !== exp) begin
          failures++;
          $display("FAIL %s: {p1,p2,p3,busy,done} actual=%b expected=%b", t, act, exp);
        end
        checks++;
        if ((p1 && p2 && p3) || !(p1 || p2 || p3)) begin
          failures++;
          $display("FAIL R6: barrier broken actual=%b%b%b expected=not 111/000", p1, p2, p3);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);               // R1 idle after reset
    run_shift(2, 1, "R3"); wait_drain();
    run_shift(3, 2, "R2"); wait_drain();     // back to back from idle
    run_shift(1, 3, "R4"); wait_drain();
    run_shift(0, 0, "R5"); wait_drain();     // zero counts give one cycle
    run_shift(4, 0, "R5"); wait_drain();
    // R8: stray start mid-run is dropped
    run_shift(3, 2, "R8");
    repeat (4) @(negedge clk);
    start = 1'b1; dwell = 8'd9; ovl = 4'd7;
    @(negedge clk); start = 1'b0;
    wait_drain();
    // R10: count inputs change after acceptance
    run_shift(2, 2, "R10");
    dwell = 8'd6; ovl = 4'd5;
    wait_drain();
    // R9: start in integrate mode is refused
    @(negedge clk);
    idle_tag = "R9";
    mode = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    idle_tag = "R1";
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule